// File: doc/BRIEF.md
# Debug Communications Mailbox Channel

This block carries single 32-bit words in both directions between a processor core and an external debugger. Each direction has a one-word mailbox with an occupancy flag. The outbound mailbox is written by the processor and drained by the debugger. The inbound mailbox is written by the debugger and drained by the processor.

A read-only status word gives both sides the same view. It holds a fixed version nibble and both flags. Each side polls that word before it writes, so neither side overruns the other.

The processor reaches the block through a register-transfer port. That port carries an index, a read strobe, a write strobe and 32-bit data. The debugger reaches it through a plain parallel register port, which stands in for a scan chain. On that port a select bit chooses between the status word and the data path.

Each mailbox is a two-state machine with the states SLOT_EMPTY and SLOT_FULL:

- **SLOT_EMPTY to SLOT_FULL** happens on an accepted write. The written word is captured at the same time.
- **SLOT_FULL to SLOT_EMPTY** happens when the opposite side reads the data.
- In SLOT_FULL, a write is not taken.

Top module: `dbg_mailbox_chan`

## Requirements
- R1: Status reads return 4'b0011 in bits 31:28, and zero in reserved bits 27:2.
- R2: Status bit 1 (W) becomes 1 on the edge after a processor write to index 1 while W=0.
- R3: Status bit 0 (R) becomes 1 on the edge after a debugger data write (select 1) while R=0.
- R4: A processor read at index 1 returns the inbound word in the same cycle, and R is 0 after the next edge.
- R5: A debugger data read (select 1) returns the outbound word in the same cycle, and W is 0 after the next edge.
- R6: A write into a mailbox whose flag is 1 changes neither the held word nor the flag.
- R7: Writes aimed at the status word (processor index 0, debugger select 0) change nothing.
- R8: A write and a drain of the same mailbox in one cycle leave it full with the new word if it was empty, and empty with the old word kept if it was full.
- R9: While reset is low, both flags are 0 and both held words read as zero.
- R10: A read data output is zero when its read strobe is low. The processor read data is also zero for indices 2 and 3.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cp_idx | input | 2 | Processor register index: 0 status, 1 data |
| cp_rd | input | 1 | Processor read strobe |
| cp_wr | input | 1 | Processor write strobe |
| cp_wdata | input | 32 | Processor write data |
| cp_rdata | output | 32 | Processor read data, combinational |
| dbg_sel | input | 1 | Debugger select: 0 status, 1 data |
| dbg_rd | input | 1 | Debugger read strobe |
| dbg_wr | input | 1 | Debugger write strobe |
| dbg_wdata | input | 32 | Debugger write data |
| dbg_rdata | output | 32 | Debugger read data, combinational |

## Verification
The bench targets the following corner cases:

- **Writes into a full mailbox.** A design that wrongly accepts them would overwrite a word the other side has not yet seen.
- **Write and drain in the same cycle.** Giving the clear priority would lose a fresh word. Giving the set priority would leave a stale word posted twice.
- **Writes aimed at the status index.** A design that decoded them would disturb the flags or the version field.
- **Unmapped indices and idle cycles.** A design that failed to gate them would leak data onto the read buses.

A long random phase then mixes all of these against a behavioural model.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    typedef enum logic {
        SLOT_EMPTY = 1'b0,
        SLOT_FULL  = 1'b1
    } slot_state_e;

    localparam int unsigned IDX_STATUS = 0;
    localparam int unsigned IDX_DATA   = 1;
endpackage

// File: rtl/mbx_slot.sv
module mbx_slot #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic          full,
    output logic [DW-1:0] data
);
    import mbx_pkg::*;

    slot_state_e   state_q, state_d;
    logic          load;
    logic [DW-1:0] data_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SLOT_EMPTY;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SLOT_EMPTY: if (push) state_d = SLOT_FULL;
            SLOT_FULL:  if (pop)  state_d = SLOT_EMPTY;
            default:              state_d = SLOT_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full = (state_q == SLOT_FULL);
        load = (state_q == SLOT_EMPTY) && push;
        data = data_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    data_q <= '0;
        else if (load) data_q <= push_data;
    end
endmodule

// File: rtl/mbx_status.sv
module mbx_status #(
    parameter int          DW      = 32,
    parameter int          VER_W   = 4,
    parameter logic [VER_W-1:0] VERSION = 4'b0011
) (
    input  logic          w_flag,
    input  logic          r_flag,
    output logic [DW-1:0] word
);
    localparam int RSV_W = DW - VER_W - 2;

    always_comb word = {VERSION, {RSV_W{1'b0}}, w_flag, r_flag};
endmodule

// File: rtl/dbg_mailbox_chan.sv
module dbg_mailbox_chan #(
    parameter int               DW       = 32,
    parameter int               CP_IDX_W = 2,
    parameter int               VER_W    = 4,
    parameter logic [VER_W-1:0] VERSION  = 4'b0011
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [CP_IDX_W-1:0] cp_idx,
    input  logic                cp_rd,
    input  logic                cp_wr,
    input  logic [DW-1:0]       cp_wdata,
    output logic [DW-1:0]       cp_rdata,
    input  logic                dbg_sel,
    input  logic                dbg_rd,
    input  logic                dbg_wr,
    input  logic [DW-1:0]       dbg_wdata,
    output logic [DW-1:0]       dbg_rdata
);
    import mbx_pkg::*;

    localparam int NSLOT = 2;   // 0 outbound (cpu->dbg), 1 inbound (dbg->cpu)
    localparam int OUTB  = 0;
    localparam int INB   = 1;

    logic [NSLOT-1:0] push, pop, full;
    logic [DW-1:0]    pdata [NSLOT];
    logic [DW-1:0]    sdata [NSLOT];
    logic             cp_stat_sel, cp_data_sel;
    logic             w_full, r_full;
    logic [DW-1:0]    out_data, in_data, status;

    always_comb begin
        cp_stat_sel = (cp_idx == CP_IDX_W'(IDX_STATUS));
        cp_data_sel = (cp_idx == CP_IDX_W'(IDX_DATA));
        push[OUTB]  = cp_wr && cp_data_sel;
        pdata[OUTB] = cp_wdata;
        pop[OUTB]   = dbg_rd && dbg_sel;
        push[INB]   = dbg_wr && dbg_sel;
        pdata[INB]  = dbg_wdata;
        pop[INB]    = cp_rd && cp_data_sel;
    end

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        mbx_slot #(.DW(DW)) u_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .push      (push[g]),
            .push_data (pdata[g]),
            .pop       (pop[g]),
            .full      (full[g]),
            .data      (sdata[g])
        );
    end

    always_comb begin
        w_full   = full[OUTB];
        r_full   = full[INB];
        out_data = sdata[OUTB];
        in_data  = sdata[INB];
    end

    mbx_status #(.DW(DW), .VER_W(VER_W), .VERSION(VERSION)) u_status (
        .w_flag (w_full),
        .r_flag (r_full),
        .word   (status)
    );

    always_comb begin
        cp_rdata = '0;
        if (cp_rd) begin
            if (cp_stat_sel)      cp_rdata = status;
            else if (cp_data_sel) cp_rdata = in_data;
        end
        dbg_rdata = '0;
        if (dbg_rd) dbg_rdata = dbg_sel ? out_data : status;
    end
endmodule

// File: rtl/mbx_chk.sv
module mbx_chk #(
    parameter int DW       = 32,
    parameter int CP_IDX_W = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic [CP_IDX_W-1:0] cp_idx,
    input logic                cp_rd,
    input logic                cp_wr,
    input logic [DW-1:0]       cp_rdata,
    input logic                dbg_sel,
    input logic                dbg_rd,
    input logic                dbg_wr,
    input logic                w_full,
    input logic                r_full,
    input logic [DW-1:0]       out_data,
    input logic [DW-1:0]       in_data
);
    logic cp_data, cp_stat;
    assign cp_data = (cp_idx == CP_IDX_W'(1));
    assign cp_stat = (cp_idx == CP_IDX_W'(0));

    assert_version_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_rd && cp_stat) |-> (cp_rdata[DW-1:DW-4] == 4'b0011 && cp_rdata[DW-5:2] == '0));

    assert_w_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_wr && cp_data && !w_full) |=> w_full);

    assert_r_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_wr && dbg_sel && !r_full) |=> r_full);

    assert_r_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cp_rd && cp_data && r_full) |=> !r_full);

    assert_w_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_rd && dbg_sel && w_full) |=> !w_full);

    assert_out_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (w_full && !(dbg_rd && dbg_sel)) |=> (w_full && $stable(out_data)));

    assert_in_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_full && !(cp_rd && cp_data)) |=> (r_full && $stable(in_data)));

    assert_empty_after_reset_R9: assert property (@(posedge clk)
        !rst_n |-> (!w_full && !r_full && out_data == '0 && in_data == '0));
endmodule

bind dbg_mailbox_chan mbx_chk #(.DW(DW), .CP_IDX_W(CP_IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cp_idx   (cp_idx),
    .cp_rd    (cp_rd),
    .cp_wr    (cp_wr),
    .cp_rdata (cp_rdata),
    .dbg_sel  (dbg_sel),
    .dbg_rd   (dbg_rd),
    .dbg_wr   (dbg_wr),
    .w_full   (w_full),
    .r_full   (r_full),
    .out_data (out_data),
    .in_data  (in_data)
);

// File: tb/sim_dbg_mailbox_chan.sv
module sim_dbg_mailbox_chan;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cp_idx = '0;
    logic        cp_rd = 1'b0, cp_wr = 1'b0;
    logic [31:0] cp_wdata = '0, cp_rdata;
    logic        dbg_sel = 1'b0, dbg_rd = 1'b0, dbg_wr = 1'b0;
    logic [31:0] dbg_wdata = '0, dbg_rdata;

    int tests = 0, fails = 0;
    bit done = 1'b0;

    // behavioural model
    bit          m_w = 0, m_r = 0;
    logic [31:0] m_out = '0, m_in = '0;

    always #5 clk = ~clk;

    dbg_mailbox_chan u0 (
        .clk(clk), .rst_n(rst_n),
        .cp_idx(cp_idx), .cp_rd(cp_rd), .cp_wr(cp_wr),
        .cp_wdata(cp_wdata), .cp_rdata(cp_rdata),
        .dbg_sel(dbg_sel), .dbg_rd(dbg_rd), .dbg_wr(dbg_wr),
        .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata)
    );

    function automatic logic [31:0] stat_word();
        return {4'b0011, 26'd0, m_w, m_r};
    endfunction

    task automatic check(input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%08h expected=%08h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive after negedge, check mid-cycle, update model at posedge
    task automatic step(input string tag,
                        input bit crd, input bit cwr, input logic [1:0] cidx,
                        input logic [31:0] cwd,
                        input bit drd, input bit dwr, input bit dsel,
                        input logic [31:0] dwd);
        logic [31:0] exp_cp, exp_dbg;
        bit pw, pr, dw, dr;
        cp_rd = crd; cp_wr = cwr; cp_idx = cidx; cp_wdata = cwd;
        dbg_rd = drd; dbg_wr = dwr; dbg_sel = dsel; dbg_wdata = dwd;
        #1;
        exp_cp = '0;
        if (crd) exp_cp = (cidx == 2'd0) ? stat_word() : (cidx == 2'd1) ? m_in : 32'd0;
        exp_dbg = '0;
        if (drd) exp_dbg = dsel ? m_out : stat_word();
        check(tag, "cp_rdata", cp_rdata, exp_cp);
        check(tag, "dbg_rdata", dbg_rdata, exp_dbg);
        pw = cwr && cidx == 2'd1; pr = crd && cidx == 2'd1;
        dw = dwr && dsel;         dr = drd && dsel;
        @(posedge clk);
        if (!rst_n) begin
            m_w = 0; m_r = 0; m_out = '0; m_in = '0;
        end else begin
            if (!m_w) begin if (pw) begin m_w = 1; m_out = cwd; end end
            else if (dr) m_w = 0;
            if (!m_r) begin if (dw) begin m_r = 1; m_in = dwd; end end
            else if (pr) m_r = 0;
        end
        @(negedge clk);
    endtask

    task automatic peek(input string tag);
        // processor reads status, debugger reads status
        step(tag, 1, 0, 2'd0, 0, 1, 0, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        // R9: reset state through both ports
        step("R9", 1, 0, 2'd1, 0, 1, 0, 1, 0);
        step("R9", 1, 0, 2'd0, 0, 1, 0, 0, 0);
        step("R9", 0, 1, 2'd1, 32'h1111_1111, 0, 1, 1, 32'h2222_2222);
        step("R9", 1, 0, 2'd1, 0, 1, 0, 1, 0);
        rst_n = 1'b1;
        peek("R1");
        // R2: processor posts a word
        step("R2", 0, 1, 2'd1, 32'hA1A1_0001, 0, 0, 0, 0);
        peek("R2");
        // R6: second post while W=1 is ignored
        step("R6", 0, 1, 2'd1, 32'hB2B2_0002, 0, 0, 0, 0);
        peek("R6");
        // R5: debugger drains
        step("R5", 0, 0, 2'd0, 0, 1, 0, 1, 0);
        peek("R5");
        // R3: debugger posts a word
        step("R3", 0, 0, 2'd0, 0, 0, 1, 1, 32'hC3C3_0003);
        peek("R3");
        step("R6", 0, 0, 2'd0, 0, 0, 1, 1, 32'hD4D4_0004);
        peek("R6");
        // R4: processor collects
        step("R4", 1, 0, 2'd1, 0, 0, 0, 0, 0);
        peek("R4");
        // R7: writes aimed at status
        step("R7", 0, 1, 2'd0, 32'hFFFF_FFFF, 0, 1, 0, 32'hFFFF_FFFF);
        peek("R7");
        step("R7", 1, 0, 2'd1, 0, 1, 0, 1, 0);
        // R8: write and drain together, empty then full
        step("R8", 0, 1, 2'd1, 32'hE5E5_0005, 1, 0, 1, 0);
        peek("R8");
        step("R8", 0, 1, 2'd1, 32'hF6F6_0006, 1, 0, 1, 0);
        peek("R8");
        step("R8", 0, 0, 2'd0, 0, 1, 0, 1, 0);
        step("R8", 1, 0, 2'd1, 0, 0, 1, 1, 32'h0707_0007);
        peek("R8");
        step("R8", 1, 0, 2'd1, 0, 0, 1, 1, 32'h0808_0008);
        peek("R8");
        // R10: unmapped indices and idle strobes
        step("R10", 1, 0, 2'd2, 0, 0, 0, 1, 0);
        step("R10", 1, 1, 2'd3, 32'h1234_5678, 0, 0, 0, 0);
        step("R10", 0, 0, 2'd0, 0, 0, 0, 0, 0);
        peek("R10");
        // mixed random traffic against the model
        for (int i = 0; i < 600; i++) begin
            step("RND", bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 2'($urandom_range(0, 3)), $urandom(),
                 bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
                 bit'($urandom_range(0, 1)), $urandom());
        end
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule